// File: doc/BRIEF.md
# Multi-Step Pattern Trigger Sequencer

The block watches a bus of sense signals and steps through a small programmable graph of states, in the way the trigger logic of a logic analyser does. When a programmed pattern, or a sequence of patterns spread over many clock cycles, has been seen, it emits a one-cycle trigger pulse and raises a level interrupt. Each of the eight steps has four match groups in priority order. Each step also has a condition that counts qualifying hits against a threshold and selects a follow-up action. An optional timer can send a stalled step back to the start.

Software programs the block through an APB-style register port (reads are combinational, writes take effect on the access phase) and then sets the enable bit. The sequencer runs only while that bit and the `src_en` input are both high. `src_en` is meant to follow the enable of the upstream unit that drives the sense bus. If either one drops, all sequencing state returns to its reset value and a pending interrupt is withdrawn.

Top module: `trig_seq`

## Requirements
- R1: After reset `trig` and `irq` are low and the control word at byte offset 0x000 reads 0.
- R2: The sequencer advances only in cycles where control bit 0 (enable) and `src_en` are both 1. Otherwise it stays in step 0, counts nothing and fires nothing. Control bits [6:4] read the current step.
- R3: Step s occupies byte offsets 0x200+0x40*s. Group g keeps its mask word at +8*g and its match word at +8*g+4. The group hits when (sense & mask) equals (match & mask), so sense bits outside the mask are ignored.
- R4: Group 0 takes precedence over 1, 1 over 2, and 2 over 3. In a cycle, a hit qualifies only when the highest-priority hitting group is set in the condition word's select field [27:24].
- R5: The condition word sits at +0x20, with the threshold in [15:0]. Qualifying hits are counted, and the condition is met on the hit that brings the count to the threshold. A threshold of 0 acts as 1.
- R6: Action field [17:16] = 01 moves the sequencer, on the cycle the condition is met, to the step held in [22:20].
- R7: Action 10 raises `trig` for exactly one cycle, sets `irq`, and returns the sequencer to step 0.
- R8: Action 11 raises `trig` for one cycle and sets `irq`. Control bit 8 then reads 1, and no further trigger occurs until the block is disabled.
- R9: The hit counter and the timer clear whenever the step changes.
- R10: Timer word at +0x24 has enable in bit 31 and a cycle limit in [15:0]. When enabled, the limit-th cycle spent in the step without the condition being met sends the sequencer to step 0.
- R11: Clearing the enable bit drops `irq` and returns the step and halt flag to 0 one cycle after the write.
- R12: Action 00 keeps the step, rearms the counter, and blocks timer expiry for the rest of the stay in that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write strobe |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (combinational) |
| sense | input | SENSE_W | Monitored signals |
| src_en | input | 1 | Upstream source enabled |
| trig | output | 1 | One-cycle trigger pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench places a higher-priority group that hits but is not selected over a lower-priority group that is selected. A design that counted any hitting group would fire in the wrong cycle. It checks that a counter is not carried into a new step: a leaked count would fire step 1 on its first qualifying hit. It runs a timer limit both with and without an earlier stay-action match. A design that forgot the match would drop back to step 0, and one with a limit off by one would drop back a cycle early or late. It also holds `src_en` low while matching patterns arrive, and it lets the halt action run on. Wrong gating there would show up as early step movement or as repeated triggers.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

   typedef enum logic [1:0] {
      ACT_STAY      = 2'b00,
      ACT_GOTO      = 2'b01,
      ACT_FIRE_RST  = 2'b10,
      ACT_FIRE_HALT = 2'b11
   } act_e;

   // control word layout
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_STEP_LSB = 4;
   localparam int CTRL_HALT_BIT = 8;

   // condition word layout
   localparam int COND_ACT_LSB = 16;
   localparam int COND_NXT_LSB = 20;
   localparam int COND_SEL_LSB = 24;

   // timer word layout
   localparam int TCFG_EN_BIT = 31;

   // word index inside a step window
   localparam logic [3:0] WORD_COND = 4'd8;
   localparam logic [3:0] WORD_TCFG = 4'd9;

   // address decode
   localparam int STEP_REGION_LSB = 9;
   localparam int STEP_IDX_LSB    = 6;

endpackage

// File: rtl/trig_seq_regs.sv
module trig_seq_regs
   import trig_seq_pkg::*;
#(
   parameter int SENSE_W  = 32,
   parameter int N_STEPS  = 8,
   parameter int N_GROUPS = 4,
   parameter int CNT_W    = 16,
   parameter int STEP_W   = 3,
   parameter int ADDR_W   = 12
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         psel,
   input  logic                                         penable,
   input  logic                                         pwrite,
   input  logic [ADDR_W-1:0]                            paddr,
   input  logic [31:0]                                  pwdata,
   output logic [31:0]                                  prdata,
   output logic                                         en_o,
   output logic [N_STEPS-1:0][N_GROUPS-1:0][SENSE_W-1:0] mask_o,
   output logic [N_STEPS-1:0][N_GROUPS-1:0][SENSE_W-1:0] match_o,
   output logic [N_STEPS-1:0][CNT_W-1:0]                thr_o,
   output logic [N_STEPS-1:0][1:0]                      act_o,
   output logic [N_STEPS-1:0][STEP_W-1:0]               nxt_o,
   output logic [N_STEPS-1:0][N_GROUPS-1:0]             sel_o,
   output logic [N_STEPS-1:0]                           ten_o,
   output logic [N_STEPS-1:0][CNT_W-1:0]                tlim_o,
   input  logic [STEP_W-1:0]                            stat_step_i,
   input  logic                                         stat_halt_i
);

   localparam int REGION_W = ADDR_W - STEP_REGION_LSB;

   logic              wr_en;
   logic              hit_ctrl;
   logic              hit_step;
   logic [STEP_W-1:0] sidx;
   logic [3:0]        word;
   logic              en_q;
   logic              unused_addr;

   assign wr_en    = psel & penable & pwrite;
   assign hit_ctrl = (paddr[ADDR_W-1:2] == '0);
   assign hit_step = (paddr[ADDR_W-1:STEP_REGION_LSB] == REGION_W'(1));
   assign sidx     = paddr[STEP_IDX_LSB +: STEP_W];
   assign word     = paddr[5:2];
   assign unused_addr = ^paddr[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                en_q <= 1'b0;
      else if (wr_en && hit_ctrl) en_q <= pwdata[CTRL_EN_BIT];
   end
   assign en_o = en_q;

   for (genvar s = 0; s < N_STEPS; s++) begin : g_step
      localparam logic [STEP_W-1:0] SID = STEP_W'(s);
      logic wr_here;
      assign wr_here = wr_en && hit_step && (sidx == SID);

      for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
         localparam logic [3:0] W_MASK  = 4'(2 * g);
         localparam logic [3:0] W_MATCH = 4'(2 * g + 1);
         logic [SENSE_W-1:0] mask_r;
         logic [SENSE_W-1:0] match_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mask_r  <= '0;
               match_r <= '0;
            end else if (wr_here) begin
               if (word == W_MASK)  mask_r  <= pwdata[SENSE_W-1:0];
               if (word == W_MATCH) match_r <= pwdata[SENSE_W-1:0];
            end
         end
         assign mask_o[s][g]  = mask_r;
         assign match_o[s][g] = match_r;
      end

      logic [CNT_W-1:0]    thr_r;
      logic [1:0]          act_r;
      logic [STEP_W-1:0]   nxt_r;
      logic [N_GROUPS-1:0] sel_r;
      logic                ten_r;
      logic [CNT_W-1:0]    tlim_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            thr_r  <= '0;
            act_r  <= '0;
            nxt_r  <= '0;
            sel_r  <= '0;
            ten_r  <= 1'b0;
            tlim_r <= '0;
         end else if (wr_here) begin
            if (word == WORD_COND) begin
               thr_r <= pwdata[CNT_W-1:0];
               act_r <= pwdata[COND_ACT_LSB +: 2];
               nxt_r <= pwdata[COND_NXT_LSB +: STEP_W];
               sel_r <= pwdata[COND_SEL_LSB +: N_GROUPS];
            end
            if (word == WORD_TCFG) begin
               ten_r  <= pwdata[TCFG_EN_BIT];
               tlim_r <= pwdata[CNT_W-1:0];
            end
         end
      end

      assign thr_o[s]  = thr_r;
      assign act_o[s]  = act_r;
      assign nxt_o[s]  = nxt_r;
      assign sel_o[s]  = sel_r;
      assign ten_o[s]  = ten_r;
      assign tlim_o[s] = tlim_r;
   end

   always_comb begin
      prdata = '0;
      if (hit_ctrl) begin
         prdata[CTRL_EN_BIT]               = en_q;
         prdata[CTRL_STEP_LSB +: STEP_W]   = stat_step_i;
         prdata[CTRL_HALT_BIT]             = stat_halt_i;
      end else if (hit_step) begin
         for (int g = 0; g < N_GROUPS; g++) begin
            if (word == 4'(2 * g))     prdata[SENSE_W-1:0] = mask_o[sidx][g];
            if (word == 4'(2 * g + 1)) prdata[SENSE_W-1:0] = match_o[sidx][g];
         end
         if (word == WORD_COND) begin
            prdata[CNT_W-1:0]                 = thr_o[sidx];
            prdata[COND_ACT_LSB +: 2]         = act_o[sidx];
            prdata[COND_NXT_LSB +: STEP_W]    = nxt_o[sidx];
            prdata[COND_SEL_LSB +: N_GROUPS]  = sel_o[sidx];
         end
         if (word == WORD_TCFG) begin
            prdata[TCFG_EN_BIT]  = ten_o[sidx];
            prdata[CNT_W-1:0]    = tlim_o[sidx];
         end
      end
   end

endmodule

// File: rtl/trig_seq_match.sv
module trig_seq_match #(
   parameter int SENSE_W  = 32,
   parameter int N_GROUPS = 4
) (
   input  logic [SENSE_W-1:0]                sense,
   input  logic [N_GROUPS-1:0][SENSE_W-1:0]  mask,
   input  logic [N_GROUPS-1:0][SENSE_W-1:0]  match,
   input  logic [N_GROUPS-1:0]               sel,
   output logic                              qual_o
);

   logic [N_GROUPS-1:0] hit;
   logic [N_GROUPS-1:0] win;

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_cmp
      assign hit[g] = ~|((sense ^ match[g]) & mask[g]);
      if (g == 0) begin : g_top
         assign win[g] = hit[g];
      end else begin : g_low
         assign win[g] = hit[g] & ~|hit[g-1:0];
      end
   end

   assign qual_o = |(win & sel);

endmodule

// File: rtl/trig_seq_core.sv
module trig_seq_core
   import trig_seq_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              qual,
   input  logic [CNT_W-1:0]  thr,
   input  act_e              act,
   input  logic [STEP_W-1:0] nxt,
   input  logic              ten,
   input  logic [CNT_W-1:0]  tlim,
   output logic [STEP_W-1:0] step_o,
   output logic              halt_o,
   output logic              trig_o,
   output logic              irq_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  tcnt_o
);

   logic [STEP_W-1:0] step_q;
   logic              halt_q;
   logic              trig_q;
   logic              irq_q;
   logic              held_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  tcnt_q;

   logic [CNT_W:0] thr_eff;
   logic [CNT_W:0] lim_eff;
   logic [CNT_W:0] cnt_nx;
   logic [CNT_W:0] tcnt_nx;
   logic           met;
   logic           expire;
   logic           cnt_full;
   logic           tcnt_full;

   assign thr_eff   = (thr  == '0) ? (CNT_W+1)'(1) : {1'b0, thr};
   assign lim_eff   = (tlim == '0) ? (CNT_W+1)'(1) : {1'b0, tlim};
   assign cnt_nx    = {1'b0, cnt_q}  + (CNT_W+1)'(1);
   assign tcnt_nx   = {1'b0, tcnt_q} + (CNT_W+1)'(1);
   assign cnt_full  = &cnt_q;
   assign tcnt_full = &tcnt_q;
   assign met       = qual && (cnt_nx >= thr_eff);
   assign expire    = ten && !held_q && (tcnt_nx >= lim_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         halt_q <= 1'b0;
         trig_q <= 1'b0;
         irq_q  <= 1'b0;
         held_q <= 1'b0;
         cnt_q  <= '0;
         tcnt_q <= '0;
      end else if (!active) begin
         step_q <= '0;
         halt_q <= 1'b0;
         trig_q <= 1'b0;
         irq_q  <= 1'b0;
         held_q <= 1'b0;
         cnt_q  <= '0;
         tcnt_q <= '0;
      end else if (halt_q) begin
         trig_q <= 1'b0;
      end else begin
         trig_q <= 1'b0;
         if (met) begin
            case (act)
               ACT_STAY: begin
                  cnt_q  <= '0;
                  held_q <= 1'b1;
                  if (ten && !tcnt_full) tcnt_q <= tcnt_q + 1'b1;
               end
               ACT_GOTO: begin
                  step_q <= nxt;
                  cnt_q  <= '0;
                  tcnt_q <= '0;
                  held_q <= 1'b0;
               end
               ACT_FIRE_RST: begin
                  trig_q <= 1'b1;
                  irq_q  <= 1'b1;
                  step_q <= '0;
                  cnt_q  <= '0;
                  tcnt_q <= '0;
                  held_q <= 1'b0;
               end
               default: begin
                  trig_q <= 1'b1;
                  irq_q  <= 1'b1;
                  halt_q <= 1'b1;
                  cnt_q  <= '0;
                  tcnt_q <= '0;
                  held_q <= 1'b0;
               end
            endcase
         end else if (expire) begin
            step_q <= '0;
            cnt_q  <= '0;
            tcnt_q <= '0;
            held_q <= 1'b0;
         end else begin
            if (qual && !cnt_full) cnt_q  <= cnt_q + 1'b1;
            if (ten && !tcnt_full) tcnt_q <= tcnt_q + 1'b1;
         end
      end
   end

   assign step_o = step_q;
   assign halt_o = halt_q;
   assign trig_o = trig_q;
   assign irq_o  = irq_q;
   assign cnt_o  = cnt_q;
   assign tcnt_o = tcnt_q;

endmodule

// File: rtl/trig_seq.sv
module trig_seq
   import trig_seq_pkg::*;
#(
   parameter int SENSE_W  = 32,
   parameter int N_STEPS  = 8,
   parameter int N_GROUPS = 4,
   parameter int CNT_W    = 16,
   parameter int ADDR_W   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               psel,
   input  logic               penable,
   input  logic               pwrite,
   input  logic [ADDR_W-1:0]  paddr,
   input  logic [31:0]        pwdata,
   output logic [31:0]        prdata,
   input  logic [SENSE_W-1:0] sense,
   input  logic               src_en,
   output logic               trig,
   output logic               irq
);

   localparam int STEP_W = $clog2(N_STEPS);

   if (SENSE_W < 1 || SENSE_W > 32) begin : g_bad_sense
      $error("trig_seq: SENSE_W must be 1..32");
   end
   if (N_STEPS < 2 || N_STEPS > 8 || (N_STEPS & (N_STEPS - 1)) != 0) begin : g_bad_steps
      $error("trig_seq: N_STEPS must be a power of two in 2..8");
   end
   if (N_GROUPS < 1 || N_GROUPS > 4) begin : g_bad_groups
      $error("trig_seq: N_GROUPS must be 1..4");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("trig_seq: CNT_W must be 1..16");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("trig_seq: ADDR_W must be at least 10");
   end

   logic                                          en_w;
   logic [N_STEPS-1:0][N_GROUPS-1:0][SENSE_W-1:0] mask_w;
   logic [N_STEPS-1:0][N_GROUPS-1:0][SENSE_W-1:0] match_w;
   logic [N_STEPS-1:0][CNT_W-1:0]                 thr_w;
   logic [N_STEPS-1:0][1:0]                       act_w;
   logic [N_STEPS-1:0][STEP_W-1:0]                nxt_w;
   logic [N_STEPS-1:0][N_GROUPS-1:0]              sel_w;
   logic [N_STEPS-1:0]                            ten_w;
   logic [N_STEPS-1:0][CNT_W-1:0]                 tlim_w;

   logic [STEP_W-1:0] step_w;
   logic              halt_w;
   logic [CNT_W-1:0]  cnt_w;
   logic [CNT_W-1:0]  tcnt_w;
   logic              qual_w;
   logic              active_w;

   assign active_w = en_w & src_en;

   trig_seq_regs #(
      .SENSE_W (SENSE_W),
      .N_STEPS (N_STEPS),
      .N_GROUPS(N_GROUPS),
      .CNT_W   (CNT_W),
      .STEP_W  (STEP_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .psel       (psel),
      .penable    (penable),
      .pwrite     (pwrite),
      .paddr      (paddr),
      .pwdata     (pwdata),
      .prdata     (prdata),
      .en_o       (en_w),
      .mask_o     (mask_w),
      .match_o    (match_w),
      .thr_o      (thr_w),
      .act_o      (act_w),
      .nxt_o      (nxt_w),
      .sel_o      (sel_w),
      .ten_o      (ten_w),
      .tlim_o     (tlim_w),
      .stat_step_i(step_w),
      .stat_halt_i(halt_w)
   );

   trig_seq_match #(
      .SENSE_W (SENSE_W),
      .N_GROUPS(N_GROUPS)
   ) u_match (
      .sense (sense),
      .mask  (mask_w[step_w]),
      .match (match_w[step_w]),
      .sel   (sel_w[step_w]),
      .qual_o(qual_w)
   );

   trig_seq_core #(
      .CNT_W (CNT_W),
      .STEP_W(STEP_W)
   ) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .active(active_w),
      .qual  (qual_w),
      .thr   (thr_w[step_w]),
      .act   (act_e'(act_w[step_w])),
      .nxt   (nxt_w[step_w]),
      .ten   (ten_w[step_w]),
      .tlim  (tlim_w[step_w]),
      .step_o(step_w),
      .halt_o(halt_w),
      .trig_o(trig),
      .irq_o (irq),
      .cnt_o (cnt_w),
      .tcnt_o(tcnt_w)
   );

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
   parameter int STEP_W = 3,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              src_en,
   input logic              trig,
   input logic              irq,
   input logic [STEP_W-1:0] step,
   input logic              halted,
   input logic [CNT_W-1:0]  hit_cnt,
   input logic [CNT_W-1:0]  tmr_cnt
);

   // R2: an inactive cycle leaves the sequencer at rest
   p_gate_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && src_en) |=> (!trig && !irq && step == '0 && hit_cnt == '0));

   // R7: a trigger is always accompanied by the interrupt
   p_trig_sets_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> irq);

   // R7: the interrupt only rises together with a trigger
   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> trig);

   // R8: a halted, still enabled sequencer neither moves nor fires
   p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && en && src_en) |=> (halted && $stable(step) && !trig));

   // R9: counters start from zero in a new step
   p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step != $past(step)) |-> (hit_cnt == '0 && tmr_cnt == '0));

   // R11: the interrupt persists while the block stays enabled
   p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && en && src_en) |=> irq);

endmodule

bind trig_seq trig_seq_chk #(
   .STEP_W(STEP_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en_w),
   .src_en (src_en),
   .trig   (trig),
   .irq    (irq),
   .step   (step_w),
   .halted (halt_w),
   .hit_cnt(cnt_w),
   .tmr_cnt(tcnt_w)
);

// File: tb/trig_seq_tb_top.sv
module trig_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        psel, penable, pwrite;
   logic [11:0] paddr;
   logic [31:0] pwdata;
   logic [31:0] prdata;
   logic [31:0] sense;
   logic        src_en;
   logic        trig;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   trig_seq dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .psel   (psel),
      .penable(penable),
      .pwrite (pwrite),
      .paddr  (paddr),
      .pwdata (pwdata),
      .prdata (prdata),
      .sense  (sense),
      .src_en (src_en),
      .trig   (trig),
      .irq    (irq)
   );

   // sense[36:5], trig[4], irq[3], step[2:0]
   localparam logic [36:0] VEC [8] = '{
      {32'h0000_0000, 1'b0, 1'b0, 3'd0},   // idle
      {32'h0000_00A5, 1'b0, 1'b0, 3'd0},   // R3 R5 first qualifying hit
      {32'h0000_00A4, 1'b0, 1'b0, 3'd0},   // R3 mismatch in masked bits
      {32'h00FF_12A5, 1'b0, 1'b0, 3'd1},   // R3 unmasked bits ignored, R6 goto step 1
      {32'h5000_0000, 1'b0, 1'b0, 3'd1},   // R9 fresh count in step 1
      {32'h0000_0000, 1'b0, 1'b0, 3'd1},
      {32'h5F00_0000, 1'b1, 1'b1, 3'd0},   // R7 fire and return
      {32'h0000_0000, 1'b0, 1'b1, 3'd0}    // R7 pulse is one cycle
   };

   function automatic logic [11:0] a_mask(int s, int g);
      return 12'(12'h200 + s * 64 + g * 8);
   endfunction
   function automatic logic [11:0] a_match(int s, int g);
      return 12'(12'h200 + s * 64 + g * 8 + 4);
   endfunction
   function automatic logic [11:0] a_cond(int s);
      return 12'(12'h200 + s * 64 + 32);
   endfunction
   function automatic logic [11:0] a_tmr(int s);
      return 12'(12'h200 + s * 64 + 36);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      paddr   = a;
      pwdata  = d;
      psel    = 1'b1;
      pwrite  = 1'b1;
      penable = 1'b0;
      @(posedge clk); #1;
      penable = 1'b1;
      @(posedge clk); #1;
      psel    = 1'b0;
      penable = 1'b0;
      pwrite  = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      paddr = a;
      #1;
      d = prdata;
   endtask

   task automatic cyc(input logic [31:0] v);
      sense = v;
      @(posedge clk); #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL R1 watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      paddr = '0; pwdata = '0; sense = '0; src_en = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1 trig after reset", 32'(trig), 32'd0);
      chk("R1 irq after reset", 32'(irq), 32'd0);
      rd(12'h000, d);
      chk("R1 control word", d, 32'h0);

      // main program: step0 goto 1 after two A5 hits, step1 fire after two 5x hits
      wr(a_mask(0, 0), 32'h0000_00FF);
      wr(a_match(0, 0), 32'h0000_00A5);
      wr(a_cond(0), 32'h0111_0002);
      wr(a_mask(1, 0), 32'hF000_0000);
      wr(a_match(1, 0), 32'h5000_0000);
      wr(a_cond(1), 32'h0102_0002);
      rd(a_cond(0), d);
      chk("R5 condition readback", d, 32'h0111_0002);

      // R2 enable set but upstream source off
      wr(12'h000, 32'h1);
      for (int i = 0; i < 3; i++) cyc(32'h0000_00A5);
      chk("R2 no trigger while source off", 32'(trig), 32'd0);
      rd(12'h000, d);
      chk("R2 step held at 0", d, 32'h1);
      sense  = '0;
      src_en = 1'b1;

      for (int i = 0; i < 8; i++) begin
         cyc(VEC[i][36:5]);
         chk("R3/R5/R6/R7/R9 table trig", 32'(trig), 32'(VEC[i][4]));
         chk("R3/R5/R6/R7/R9 table irq", 32'(irq), 32'(VEC[i][3]));
         rd(12'h000, d);
         chk("R3/R5/R6/R7/R9 table step", 32'(d[6:4]), 32'(VEC[i][2:0]));
      end

      // R11 disable clears interrupt and state
      wr(12'h000, 32'h0);
      cyc(32'h0);
      chk("R11 irq cleared", 32'(irq), 32'd0);
      rd(12'h000, d);
      chk("R11 control after disable", d, 32'h0);

      // R4 priority: group0 hits but is not selected, group1 selected
      wr(a_mask(0, 0), 32'h1);
      wr(a_match(0, 0), 32'h1);
      wr(a_mask(0, 1), 32'h2);
      wr(a_match(0, 1), 32'h2);
      wr(a_cond(0), 32'h0202_0001);
      wr(12'h000, 32'h1);
      cyc(32'h3);
      chk("R4 higher group masks selected one", 32'(trig), 32'd0);
      cyc(32'h0);
      chk("R4 unselected catch-all group", 32'(trig), 32'd0);
      cyc(32'h2);
      chk("R4 selected group wins", 32'(trig), 32'd1);
      wr(12'h000, 32'h0);
      cyc(32'h0);

      // R5 threshold zero behaves as one
      wr(a_cond(0), 32'h0202_0000);
      wr(12'h000, 32'h1);
      cyc(32'h2);
      chk("R5 zero threshold fires on first hit", 32'(trig), 32'd1);
      cyc(32'h0);
      chk("R7 trigger lasts one cycle", 32'(trig), 32'd0);
      wr(12'h000, 32'h0);
      cyc(32'h0);

      // R8 fire and halt, group2 always hits
      wr(a_cond(0), 32'h0403_0001);
      wr(12'h000, 32'h1);
      cyc(32'h0);
      chk("R8 halt action fires", 32'(trig), 32'd1);
      rd(12'h000, d);
      chk("R8 halted flag", d, 32'h101);
      cyc(32'h0);
      chk("R8 no retrigger", 32'(trig), 32'd0);
      cyc(32'h2);
      chk("R8 still silent", 32'(trig), 32'd0);
      chk("R8 irq held", 32'(irq), 32'd1);
      wr(12'h000, 32'h0);
      cyc(32'h0);
      rd(12'h000, d);
      chk("R11 halt released by disable", d, 32'h0);
      chk("R11 irq low after halt", 32'(irq), 32'd0);

      // R10 timer expiry in step 1 (limit 3)
      wr(a_mask(0, 0), 32'h0000_00FF);
      wr(a_match(0, 0), 32'h0000_00A5);
      wr(a_cond(0), 32'h0111_0001);
      wr(a_mask(1, 0), 32'h0000_00FF);
      wr(a_match(1, 0), 32'h0000_005A);
      wr(a_cond(1), 32'h0102_0001);
      wr(a_tmr(1), 32'h8000_0003);
      wr(12'h000, 32'h1);
      cyc(32'h0000_00A5);
      rd(12'h000, d);
      chk("R10 entered step 1", d, 32'h11);
      cyc(32'h0);
      cyc(32'h0);
      rd(12'h000, d);
      chk("R10 still in step 1 before limit", d, 32'h11);
      cyc(32'h0);
      rd(12'h000, d);
      chk("R10 timer expiry returns to 0", d, 32'h01);
      wr(12'h000, 32'h0);
      cyc(32'h0);

      // R12 stay action suppresses the timer
      wr(a_cond(1), 32'h0100_0001);
      wr(12'h000, 32'h1);
      cyc(32'h0000_00A5);
      cyc(32'h0000_005A);
      chk("R12 stay does not fire", 32'(trig), 32'd0);
      for (int i = 0; i < 4; i++) cyc(32'h0);
      rd(12'h000, d);
      chk("R12 step kept past timer limit", d, 32'h11);
      chk("R12 no interrupt", 32'(irq), 32'd0);

      done = 1'b1;
      finish_run();
   end

endmodule